// File: doc/BRIEF.md
# ROM Integrity Checker Sequencer

This block is the control sequencer that runs exactly once after reset to prove that a ROM holds its intended contents before the system bus may fetch from it. It walks a read address upward from zero and streams every word below the expected-digest region to an external hash engine over a valid/ready/last channel. It then reads the top eight words, which hold the expected 256-bit digest, into a local buffer. When the engine returns its digest, the sequencer runs a word-by-word comparison. Once the comparison ends, it hands the ROM to the bus.

The sequencer is built to resist fault injection. Its states are sparsely encoded. It moves forward only on three internal completion events: the address counter reaching the top, the hash response arriving, and the comparison finishing. Any of these events in a state that does not expect it sends the machine into a sticky trap state. A local escalation input does the same. In the trap state the fatal alert is raised and the multi-bit done flag stays false, so boot cannot continue. After handoff the address counter is frozen at the top word, and any movement of it is treated as a fault.

Top module: `rom_check_seq`

## Requirements
- R1: After reset is released, the block is in the hashing state: `hash_valid_o` is 1, `rom_addr_o` is 0, `hash_last_o` is 0, `alert_o` is 0, and `done_o`, `sel_bus_o` and `good_o` all read the false code 4'b1001.
- R2: In the hashing state, words at addresses 0 up to ROM_WORDS-9 are offered on `hash_data_o` in ascending order, each equal to `rom_rdata_i` at that address. The address advances only on a cycle with `hash_valid_o` and `hash_ready_i` both high, and data and address hold while `hash_ready_i` is low.
- R3: `hash_last_o` is high only while the word at address ROM_WORDS-9 is offered, and it is sent exactly once.
- R4: After the last hashed word is accepted, the eight top words are read in eight cycles. Word i (address ROM_WORDS-8+i) is compared with bits [32i+31:32i] of `digest_i` as captured on the cycle `digest_valid_i` is accepted. `good_o` reads 4'b0110 after handoff only if all eight words match, and it reads 4'b1001 otherwise.
- R5: `done_o` and `sel_bus_o` read the true code 4'b0110 only once the comparison has completed (handoff), and they read 4'b1001 in every other state.
- R6: `digest_valid_i` high in any state other than waiting for the digest sends the block to the trap state. This includes during hashing, during the eight-cycle top-word read, and after handoff. With zero stalls, a response must arrive at least 9 cycles after the cycle on which the last word was accepted.
- R7: `esc_i` high on any clock edge, including after handoff, sends the block to the trap state on that edge.
- R8: In the trap state, `alert_o` is 1, `hash_valid_o` is 0, and `done_o`, `sel_bus_o` and `good_o` read 4'b1001. The trap state persists until the next reset.
- R9: After handoff, `rom_addr_o` stays at ROM_WORDS-1. Any change of the counter away from that value sends the block to the trap state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esc_i | input | 1 | Local escalation request |
| rom_addr_o | output | $clog2(ROM_WORDS) | ROM read address driven by the sequencer |
| rom_rdata_i | input | DW | ROM word at `rom_addr_o` (same-cycle) |
| hash_valid_o | output | 1 | Word offered to the hash engine |
| hash_ready_i | input | 1 | Hash engine accepts the offered word |
| hash_data_o | output | DW | Word sent to the hash engine |
| hash_last_o | output | 1 | Marks the final hashed word |
| digest_valid_i | input | 1 | Hash engine digest response strobe |
| digest_i | input | DIG_WORDS*DW | Digest returned by the hash engine |
| sel_bus_o | output | 4 | Access-mux select, 4'b0110 gives the ROM to the bus |
| done_o | output | 4 | Check complete, multi-bit boolean |
| good_o | output | 4 | Digest matched, multi-bit boolean |
| alert_o | output | 1 | Fatal alert, sticky |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of the ROM contents: offered data and address hold under back-pressure, the last marker sits only on the final hashed address, escalation and misplaced digest strobes lead to the alert on the next edge, the alert never drops, and handoff holds the address at the top word with done and alert never both active. What only the bench scenarios can show is the content-dependent result: that the stream carries exactly the right words in order, that a single corrupted digest word in any position clears `good_o`, and that the boundary between a digest arriving during the top-word read (trap) and one arriving just after it (accepted) falls where R6 puts it.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Multi-bit booleans: any other pattern is neither true nor false.
  localparam logic [3:0] MUBI_TRUE  = 4'b0110;
  localparam logic [3:0] MUBI_FALSE = 4'b1001;

  // Sparse sequencer states; every unlisted code decodes as a trap.
  typedef enum logic [5:0] {
    S_HASH = 6'b010011,
    S_TOP  = 6'b100110,
    S_WAIT = 6'b111000,
    S_CMP  = 6'b001101,
    S_DONE = 6'b110101,
    S_TRAP = 6'b011110
  } rcs_state_e;

  function automatic logic [3:0] to_mubi(input logic b);
    return b ? MUBI_TRUE : MUBI_FALSE;
  endfunction

endpackage

// File: rtl/rcs_addr_ctr.sv
module rcs_addr_ctr #(
  parameter int unsigned AW  = 13,
  parameter int unsigned TOP = 8191
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          at_top_o,
  output logic          done_o
);
  localparam logic [AW-1:0] TopAddr = AW'(TOP);

  logic [AW-1:0] addr_q;

  assign at_top_o = (addr_q == TopAddr);
  // Completion is a request to step past the top word.
  assign done_o   = inc_i & at_top_o;
  assign addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i && !at_top_o) begin
      addr_q <= addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rcs_compare.sv
module rcs_compare #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NW*DW-1:0] dig_i,
  input  logic [NW*DW-1:0] exp_i,
  output logic            done_o,
  output logic            match_o
);
  localparam int unsigned IW = $clog2(NW);
  localparam logic [IW-1:0] LastIdx = IW'(NW - 1);

  logic          running_q, ok_q, done_q, match_q;
  logic [IW-1:0] idx_q;
  logic          word_eq;

  function automatic logic words_equal(input logic [NW*DW-1:0] a,
                                       input logic [NW*DW-1:0] b,
                                       input logic [IW-1:0] i);
    return a[i*DW +: DW] == b[i*DW +: DW];
  endfunction

  assign word_eq = words_equal(dig_i, exp_i, idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      ok_q      <= 1'b0;
      done_q    <= 1'b0;
      match_q   <= 1'b0;
      idx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        running_q <= 1'b1;
        ok_q      <= 1'b1;
        idx_q     <= '0;
      end else if (running_q) begin
        if (idx_q == LastIdx) begin
          running_q <= 1'b0;
          done_q    <= 1'b1;
          match_q   <= ok_q & word_eq;
        end else begin
          idx_q <= idx_q + 1'b1;
          ok_q  <= ok_q & word_eq;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign match_o = match_q;
endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
  import rcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       esc_i,
  input  logic       last_fire_i,
  input  logic       ctr_done_i,
  input  logic       dig_done_i,
  input  logic       cmp_done_i,
  input  logic       ctr_glitch_i,
  output rcs_state_e state_o
);
  rcs_state_e state_q, state_d;

  always_comb begin
    state_d = S_TRAP;
    case (state_q)
      S_HASH: begin
        if (esc_i || ctr_done_i || dig_done_i || cmp_done_i) state_d = S_TRAP;
        else if (last_fire_i)                                  state_d = S_TOP;
        else                                                   state_d = S_HASH;
      end
      S_TOP: begin
        if (esc_i || dig_done_i || cmp_done_i) state_d = S_TRAP;
        else if (ctr_done_i)                   state_d = S_WAIT;
        else                                   state_d = S_TOP;
      end
      S_WAIT: begin
        if (esc_i || ctr_done_i || cmp_done_i) state_d = S_TRAP;
        else if (dig_done_i)                   state_d = S_CMP;
        else                                   state_d = S_WAIT;
      end
      S_CMP: begin
        if (esc_i || ctr_done_i || dig_done_i) state_d = S_TRAP;
        else if (cmp_done_i)                   state_d = S_DONE;
        else                                   state_d = S_CMP;
      end
      S_DONE: begin
        if (esc_i || ctr_done_i || dig_done_i || cmp_done_i || ctr_glitch_i)
          state_d = S_TRAP;
        else
          state_d = S_DONE;
      end
      default: state_d = S_TRAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_HASH;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/rom_check_seq.sv
module rom_check_seq
  import rcs_pkg::*;
#(
  parameter int unsigned ROM_WORDS = 8192,
  parameter int unsigned DW        = 32,
  parameter int unsigned DIG_WORDS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        esc_i,
  output logic [$clog2(ROM_WORDS)-1:0] rom_addr_o,
  input  logic [DW-1:0]               rom_rdata_i,
  output logic                        hash_valid_o,
  input  logic                        hash_ready_i,
  output logic [DW-1:0]               hash_data_o,
  output logic                        hash_last_o,
  input  logic                        digest_valid_i,
  input  logic [DIG_WORDS*DW-1:0]     digest_i,
  output logic [3:0]                  sel_bus_o,
  output logic [3:0]                  done_o,
  output logic [3:0]                  good_o,
  output logic                        alert_o
);
  localparam int unsigned AW = $clog2(ROM_WORDS);
  localparam int unsigned IW = $clog2(DIG_WORDS);
  localparam logic [AW-1:0] ExpBase  = AW'(ROM_WORDS - DIG_WORDS);
  localparam logic [AW-1:0] LastHash = AW'(ROM_WORDS - DIG_WORDS - 1);

  rcs_state_e state;
  logic st_hash, st_top, st_wait, st_done, st_trap;
  logic hash_fire, last_fire, ctr_inc, ctr_done, at_top, ctr_glitch;
  logic dig_done, cmp_done, cmp_match;
  logic [AW-1:0] addr;
  logic [IW-1:0] exp_idx;
  logic [DW-1:0] exp_w [DIG_WORDS];
  logic [DIG_WORDS*DW-1:0] exp_flat, digest_q;

  // Named state decodes, shared with the checker.
  assign st_hash = (state == S_HASH);
  assign st_top  = (state == S_TOP);
  assign st_wait = (state == S_WAIT);
  assign st_done = (state == S_DONE);
  assign st_trap = !(st_hash || st_top || st_wait || st_done || state == S_CMP);

  assign hash_valid_o = st_hash;
  assign hash_data_o  = rom_rdata_i;
  assign hash_last_o  = st_hash && (addr == LastHash);
  assign hash_fire    = st_hash && hash_ready_i;
  assign last_fire    = hash_fire && hash_last_o;
  assign ctr_inc      = hash_fire || st_top;
  assign dig_done     = digest_valid_i;
  assign ctr_glitch   = st_done && !at_top;

  rcs_addr_ctr #(.AW(AW), .TOP(ROM_WORDS - 1)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (ctr_inc),
    .addr_o  (addr),
    .at_top_o(at_top),
    .done_o  (ctr_done)
  );

  assign exp_idx = IW'(addr - ExpBase);

  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_exp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           exp_w[g] <= '0;
      else if (st_top && exp_idx == IW'(g))  exp_w[g] <= rom_rdata_i;
    end
    assign exp_flat[g*DW +: DW] = exp_w[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        digest_q <= '0;
    else if (st_wait && digest_valid_i) digest_q <= digest_i;
  end

  rcs_compare #(.DW(DW), .NW(DIG_WORDS)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(st_wait && digest_valid_i),
    .dig_i  (digest_q),
    .exp_i  (exp_flat),
    .done_o (cmp_done),
    .match_o(cmp_match)
  );

  rcs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .esc_i       (esc_i),
    .last_fire_i (last_fire),
    .ctr_done_i  (ctr_done),
    .dig_done_i  (dig_done),
    .cmp_done_i  (cmp_done),
    .ctr_glitch_i(ctr_glitch),
    .state_o     (state)
  );

  assign rom_addr_o = addr;
  assign done_o     = to_mubi(st_done);
  assign sel_bus_o  = to_mubi(st_done);
  assign good_o     = to_mubi(st_done && cmp_match);
  assign alert_o    = st_trap;
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk
  import rcs_pkg::*;
#(
  parameter int unsigned ROM_WORDS = 8192,
  parameter int unsigned DW        = 32,
  parameter int unsigned DIG_WORDS = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        esc_i,
  input logic [$clog2(ROM_WORDS)-1:0] rom_addr_o,
  input logic                        hash_valid_o,
  input logic                        hash_ready_i,
  input logic [DW-1:0]               hash_data_o,
  input logic                        hash_last_o,
  input logic                        digest_valid_i,
  input logic                        st_wait,
  input logic [3:0]                  done_o,
  input logic [3:0]                  good_o,
  input logic                        alert_o
);
  localparam int unsigned AW = $clog2(ROM_WORDS);
  localparam logic [AW-1:0] TopAddr  = AW'(ROM_WORDS - 1);
  localparam logic [AW-1:0] LastHash = AW'(ROM_WORDS - DIG_WORDS - 1);

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_valid_o && !hash_ready_i && !esc_i && !digest_valid_i |=>
      hash_valid_o && $stable(hash_data_o) && $stable(rom_addr_o));

  // R3
  last_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_last_o |-> hash_valid_o && rom_addr_o == LastHash);

  // R4
  good_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o == MUBI_TRUE |-> done_o == MUBI_TRUE);

  // R5
  done_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == MUBI_TRUE || done_o == MUBI_FALSE);

  // R6
  stray_digest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digest_valid_i && !st_wait |=> alert_o);

  // R7
  esc_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_i |=> alert_o);

  // R8
  alert_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);

  // R8
  trap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> done_o == MUBI_FALSE && !hash_valid_o);

  // R9
  handoff_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == MUBI_TRUE |-> rom_addr_o == TopAddr);

  // R9
  handoff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == MUBI_TRUE && !esc_i && !digest_valid_i |=> done_o == MUBI_TRUE);
endmodule

bind rom_check_seq rcs_chk #(
  .ROM_WORDS(ROM_WORDS), .DW(DW), .DIG_WORDS(DIG_WORDS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .esc_i         (esc_i),
  .rom_addr_o    (rom_addr_o),
  .hash_valid_o  (hash_valid_o),
  .hash_ready_i  (hash_ready_i),
  .hash_data_o   (hash_data_o),
  .hash_last_o   (hash_last_o),
  .digest_valid_i(digest_valid_i),
  .st_wait       (st_wait),
  .done_o        (done_o),
  .good_o        (good_o),
  .alert_o       (alert_o)
);

// File: tb/tb_rom_check_seq.sv
`timescale 1ns/1ps
module tb_rom_check_seq;
  localparam int unsigned NWORDS = 64;
  localparam int unsigned DW     = 32;
  localparam int unsigned NDIG   = 8;
  localparam int unsigned AW     = $clog2(NWORDS);
  localparam int unsigned NHASH  = NWORDS - NDIG;
  localparam logic [3:0] T = 4'b0110;
  localparam logic [3:0] F = 4'b1001;

  typedef struct packed {
    logic [7:0] rdy;   // ready pattern, bit (cycle mod 8)
    logic [7:0] dly;   // cycles from last accept to digest strobe
    logic [3:0] flip;  // digest word to corrupt, 8 = none
    logic       good;
    logic       trap;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{8'hFF, 8'd10, 4'd8, 1'b1, 1'b0},
    '{8'hA5, 8'd12, 4'd8, 1'b1, 1'b0},
    '{8'h11, 8'd30, 4'd8, 1'b1, 1'b0},
    '{8'hFF, 8'd10, 4'd0, 1'b0, 1'b0},
    '{8'h6C, 8'd15, 4'd7, 1'b0, 1'b0},
    '{8'h3C, 8'd9,  4'd5, 1'b0, 1'b0},
    '{8'hFF, 8'd8,  4'd8, 1'b0, 1'b1},
    '{8'hFF, 8'd3,  4'd8, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, esc = 1'b0;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_rdata, hash_data;
  logic hash_valid, hash_ready = 1'b0, hash_last, dig_valid = 1'b0, alert;
  logic [NDIG*DW-1:0] digest = '0;
  logic [3:0] sel_bus, done, good;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] dig_word(input int i);
    return 32'hD16E_0000 + 32'(i) * 32'h0101_0101;
  endfunction

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    if (int'(a) < NHASH) return 32'(a) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
    return dig_word(int'(a) - NHASH);
  endfunction

  assign rom_rdata = rom_word(rom_addr);

  rom_check_seq #(.ROM_WORDS(NWORDS), .DW(DW), .DIG_WORDS(NDIG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .esc_i(esc),
    .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .hash_valid_o(hash_valid), .hash_ready_i(hash_ready),
    .hash_data_o(hash_data), .hash_last_o(hash_last),
    .digest_valid_i(dig_valid), .digest_i(digest),
    .sel_bus_o(sel_bus), .done_o(done), .good_o(good), .alert_o(alert)
  );

  task automatic chk(input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; esc = 1'b0; hash_ready = 1'b0; dig_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.1;
  endtask

  // Streams the hashed region, then returns a digest after dly cycles.
  task automatic run_vec(input vec_t v);
    int sent = 0, derr = 0, lerr = 0, cyc = 0;
    for (int i = 0; i < NDIG; i++) begin
      digest[i*DW +: DW] = dig_word(i) ^ ((int'(v.flip) == i) ? 32'h8 : 32'h0);
    end
    do_reset();
    while (sent < int'(NHASH) && cyc < 4000) begin
      @(negedge clk);
      hash_ready = v.rdy[cyc[2:0]];
      cyc++;
      #0.1;
      if (hash_valid && hash_ready) begin
        if (int'(rom_addr) != sent || hash_data != rom_word(AW'(sent))) derr++;
        if (hash_last != (sent == int'(NHASH) - 1)) lerr++;
        sent++;
      end
    end
    chk(sent == int'(NHASH), "R2 words accepted", 32'(sent), 32'(NHASH));
    chk(derr == 0, "R2 word order/content errors", 32'(derr), 0);
    chk(lerr == 0, "R3 last marker errors", 32'(lerr), 0);
    repeat (int'(v.dly)) @(negedge clk);
    hash_ready = 1'b0;
    dig_valid = 1'b1;
    @(negedge clk);
    dig_valid = 1'b0;
    for (int k = 0; k < 40 && done != T && !alert; k++) @(negedge clk);
    if (v.trap) begin
      chk(alert == 1'b1, "R6 digest outside wait traps", 32'(alert), 1);
      chk(done == F && good == F, "R8 trap done/good false", {24'd0, done, good}, {24'd0, F, F});
    end else begin
      chk(done == T && sel_bus == T, "R5 handoff done/sel", {24'd0, done, sel_bus}, {24'd0, T, T});
      chk(good == (v.good ? T : F), "R4 digest compare result", 32'(good), 32'(v.good ? T : F));
      chk(alert == 1'b0, "R5 no alert after clean run", 32'(alert), 0);
      repeat (20) @(negedge clk);
      chk(rom_addr == AW'(NWORDS - 1) && done == T, "R9 address frozen at top",
          32'(rom_addr), 32'(NWORDS - 1));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R1 watchdog actual=150000 expected=<150000 cycles");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk(hash_valid && rom_addr == '0 && !hash_last, "R1 hashing from address 0",
        {30'd0, hash_valid, hash_last}, 32'h2);
    chk(done == F && sel_bus == F && good == F, "R1 mubi outputs false",
        {20'd0, done, sel_bus, good}, {20'd0, F, F, F});
    chk(alert == 1'b0, "R1 alert low", 32'(alert), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R7 escalation mid-stream, R8 stickiness, R1 recovery by reset
    do_reset();
    hash_ready = 1'b1;
    repeat (10) @(negedge clk);
    esc = 1'b1;
    @(negedge clk);
    esc = 1'b0;
    #0.1;
    chk(alert == 1'b1, "R7 escalation while hashing", 32'(alert), 1);
    chk(!hash_valid && good == F, "R8 stream stops in trap", {28'd0, good}, {28'd0, F});
    repeat (30) @(negedge clk);
    chk(alert == 1'b1 && done == F, "R8 trap sticky", {27'd0, alert, done}, {27'd1, F});
    do_reset();
    chk(alert == 1'b0 && hash_valid, "R1 reset clears trap", 32'(alert), 0);

    // R6 digest strobe during hashing
    do_reset();
    dig_valid = 1'b1;
    @(negedge clk);
    dig_valid = 1'b0;
    #0.1;
    chk(alert == 1'b1, "R6 digest during hashing traps", 32'(alert), 1);

    // R7 escalation after handoff
    run_vec(VEC[0]);
    esc = 1'b1;
    @(negedge clk);
    esc = 1'b0;
    #0.1;
    chk(alert == 1'b1 && done == F && sel_bus == F, "R7 escalation after handoff",
        {27'd0, alert, done}, {27'd1, F});

    // R6 stray digest after handoff
    run_vec(VEC[1]);
    dig_valid = 1'b1;
    @(negedge clk);
    dig_valid = 1'b0;
    #0.1;
    chk(alert == 1'b1 && good == F, "R6 digest after handoff traps", 32'(alert), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule